// File: doc/BRIEF.md
# Byte-Pattern Memory Cell Tester

This block checks one memory address. It writes eight fixed byte patterns to that address, one after another. After each write it reads the same address back. It reaches the memory through a request/acknowledge port that goes to a separate strobe sequencer. The sequencer does the actual row and column timing and pulses an acknowledge when each access is complete.

A controller above the block gives it an address and a start pulse. It then waits for a one-cycle completion pulse, which carries a pass/fail flag. On a failure, the pulse also carries the position of the first pattern that read back wrong and the byte that was actually returned. The block stops at the first wrong readback. The controller can repeat the test over several addresses to find out how much memory is fitted.

Top module: `cell_tester`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the block drives no memory request and no completion pulse.
- R2: A start pulse taken while idle captures `targetAddr`. Every request of that run presents the captured address, even if `targetAddr` changes later. The first request appears in the cycle after the start pulse.
- R3: The patterns are written in this order: 0xF0, 0x0F, 0xAA, 0x55, 0xC0, 0x30, 0x0C, 0x03. The pattern at index k is written as the k-th write of a run (k counts from 0). The write byte sits on `memWrData` while `memWrite` is 1.
- R4: A request stays asserted, with its direction unchanged, until `memAck` is sampled high. An acknowledged write is followed in the very next cycle by a read (`memWrite` = 0) of the same address. An acknowledged read that matches is followed in the next cycle by the write of the next pattern.
- R5: When a readback differs from the pattern just written, no further access is issued. The next cycle carries `testDone` = 1 and `testFail` = 1, with `failIndex` set to that pattern's index (0 to 7) and `failValue` set to the byte read.
- R6: When all eight readbacks match, the cycle after the eighth read acknowledge carries `testDone` = 1 and `testFail` = 0. A run with no waiting then takes exactly 16 requests.
- R7: `testDone` is high for exactly one cycle and never together with `memReq`. The block is idle again in the following cycle.
- R8: A start pulse that arrives while a run is in progress has no effect on the address, the pattern order or the result.
- R9: A `memAck` that arrives while the block is idle has no effect. No request and no completion pulse follow from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Begin a test of `targetAddr` (used only while idle) |
| targetAddr | input | ADDR_W | Address under test |
| memReq | output | 1 | Access request to the sequencer |
| memWrite | output | 1 | 1 = write access, 0 = read access |
| memAddr | output | ADDR_W | Access address |
| memWrData | output | 8 | Byte to write |
| memRdData | input | 8 | Byte read, valid with `memAck` on a read |
| memAck | input | 1 | One-cycle completion pulse from the sequencer |
| testDone | output | 1 | One-cycle completion of a test |
| testFail | output | 1 | 1 = the address failed (valid with `testDone`) |
| failIndex | output | 3 | Index of the first failing pattern |
| failValue | output | 8 | Byte actually read at the failing pattern |

## Verification
A corrupted pattern index would first show on `memWrData` at the next write. It would also show on `failIndex` when a failure is reported. A stuck or skipped sequencing state would show within one acknowledge: a write not followed by a read, a request dropped before its acknowledge, or a completion pulse that comes early or late. The bench compares every output with a behavioural model on every clock, so any such divergence is reported in the cycle it happens. The faults the bench injects include a single corrupted readback at the first and at the last pattern, and a bit stuck high. These show whether the run stops at the right index and whether it reports the byte actually read.

// File: rtl/cell_tester_pkg.sv
package cell_tester_pkg;

  localparam int PAT_COUNT = 8;
  localparam int PAT_IDX_W = $clog2(PAT_COUNT);
  localparam int DATA_W    = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_REPORT
  } tstState_e;

  typedef struct packed {
    logic latchAddr;
    logic clearIdx;
    logic incIdx;
    logic recordFail;
    logic clearResult;
  } tstStrobe_t;

  function automatic logic [DATA_W-1:0] patternAt(input logic [PAT_IDX_W-1:0] idx);
    logic [DATA_W-1:0] val;
    case (idx)
      3'd0:    val = 8'hF0;
      3'd1:    val = 8'h0F;
      3'd2:    val = 8'hAA;
      3'd3:    val = 8'h55;
      3'd4:    val = 8'hC0;
      3'd5:    val = 8'h30;
      3'd6:    val = 8'h0C;
      default: val = 8'h03;
    endcase
    return val;
  endfunction

endpackage

// File: rtl/cell_tester_datapath.sv
module cell_tester_datapath
  import cell_tester_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tstStrobe_t           strobes,
  input  logic [ADDR_W-1:0]    targetAddr,
  input  logic [DATA_W-1:0]    memRdData,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [DATA_W-1:0]    memWrData,
  output logic                 mismatch,
  output logic                 lastPattern,
  output logic                 testFail,
  output logic [PAT_IDX_W-1:0] failIndex,
  output logic [DATA_W-1:0]    failValue
);

  localparam logic [PAT_IDX_W-1:0] LAST_IDX = PAT_IDX_W'(PAT_COUNT - 1);

  logic [ADDR_W-1:0]    addrQ;
  logic [PAT_IDX_W-1:0] patIdx;
  logic [DATA_W-1:0]    expectByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (strobes.latchAddr) begin
      addrQ <= targetAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      patIdx <= '0;
    end else if (strobes.clearIdx) begin
      patIdx <= '0;
    end else if (strobes.incIdx) begin
      patIdx <= patIdx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      testFail  <= 1'b0;
      failIndex <= '0;
      failValue <= '0;
    end else if (strobes.clearResult) begin
      testFail  <= 1'b0;
      failIndex <= '0;
      failValue <= '0;
    end else if (strobes.recordFail) begin
      testFail  <= 1'b1;
      failIndex <= patIdx;
      failValue <= memRdData;
    end
  end

  always_comb begin
    expectByte  = patternAt(patIdx);
    memWrData   = expectByte;
    memAddr     = addrQ;
    mismatch    = (memRdData != expectByte);
    lastPattern = (patIdx == LAST_IDX);
  end

  AST_FAIL_VALUE_DIFFERS: assert property (@(posedge clk) disable iff (!rstN)
    testFail |-> (failValue != patternAt(failIndex))) else $error("fail value equals pattern"); // R5

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.latchAddr && !$isunknown(addrQ)) |=> $stable(memAddr)) else $error("address moved"); // R2

endmodule

// File: rtl/cell_tester_ctrl.sv
module cell_tester_ctrl
  import cell_tester_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       memAck,
  input  logic       mismatch,
  input  logic       lastPattern,
  output tstStrobe_t strobes,
  output logic       memReq,
  output logic       memWrite,
  output logic       testDone
);

  tstState_e stateQ;
  tstState_e stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
    end else begin
      stateQ <= stateD;
    end
  end

  always_comb begin
    stateD  = stateQ;
    strobes = '0;
    case (stateQ)
      ST_IDLE: begin
        if (startPulse) begin
          strobes.latchAddr   = 1'b1;
          strobes.clearIdx    = 1'b1;
          strobes.clearResult = 1'b1;
          stateD              = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (memAck) begin
          stateD = ST_READ;
        end
      end
      ST_READ: begin
        if (memAck) begin
          if (mismatch) begin
            strobes.recordFail = 1'b1;
            stateD             = ST_REPORT;
          end else if (lastPattern) begin
            stateD = ST_REPORT;
          end else begin
            strobes.incIdx = 1'b1;
            stateD         = ST_WRITE;
          end
        end
      end
      default: begin
        stateD = ST_IDLE;
      end
    endcase
  end

  always_comb begin
    memReq   = (stateQ == ST_WRITE) || (stateQ == ST_READ);
    memWrite = (stateQ == ST_WRITE);
    testDone = (stateQ == ST_REPORT);
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    testDone |=> !testDone) else $error("done longer than one cycle"); // R7

  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    testDone |-> !memReq) else $error("request during done"); // R7

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWrite))) else $error("request dropped early"); // R4

  AST_READ_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWrite && memAck) |=> (memReq && !memWrite)) else $error("no readback"); // R4

  AST_IDLE_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!memReq && !testDone && !startPulse) |=> !memReq) else $error("request without start"); // R9

endmodule

// File: rtl/cell_tester.sv
module cell_tester
  import cell_tester_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [ADDR_W-1:0] targetAddr,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWrData,
  input  logic [7:0]        memRdData,
  input  logic              memAck,
  output logic              testDone,
  output logic              testFail,
  output logic [2:0]        failIndex,
  output logic [7:0]        failValue
);

  tstStrobe_t ctlStrobes;
  logic       mismatch;
  logic       lastPattern;

  cell_tester_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .startPulse  (startPulse),
    .memAck      (memAck),
    .mismatch    (mismatch),
    .lastPattern (lastPattern),
    .strobes     (ctlStrobes),
    .memReq      (memReq),
    .memWrite    (memWrite),
    .testDone    (testDone)
  );

  cell_tester_datapath #(
    .ADDR_W (ADDR_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (ctlStrobes),
    .targetAddr  (targetAddr),
    .memRdData   (memRdData),
    .memAddr     (memAddr),
    .memWrData   (memWrData),
    .mismatch    (mismatch),
    .lastPattern (lastPattern),
    .testFail    (testFail),
    .failIndex   (failIndex),
    .failValue   (failValue)
  );

endmodule

// File: tb/cell_tester_tb_top.sv
module cell_tester_tb_top;

  localparam int  ADDR_W   = 24;
  localparam time CLK_HALF = 5ns;
  localparam int  WATCHDOG = 20000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startPulse = 1'b0;
  logic [ADDR_W-1:0] targetAddr = '0;
  logic              memReq;
  logic              memWrite;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0]        memWrData;
  logic [7:0]        memRdData = '0;
  logic              memAck = 1'b0;
  logic              testDone;
  logic              testFail;
  logic [2:0]        failIndex;
  logic [7:0]        failValue;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  byte unsigned pats[8] = '{8'hF0, 8'h0F, 8'hAA, 8'h55, 8'hC0, 8'h30, 8'h0C, 8'h03};

  // sequencer / memory model controls
  bit   seqEnable = 1'b0;
  int   latency = 0;
  int   waitCnt = 0;
  byte unsigned lastWr = 0;
  int   readCount = 0;
  int   corruptRead = -1;
  byte unsigned stuckHigh = 0;
  int   reqCount = 0;

  // reference model
  int           mSt = 0;
  logic [ADDR_W-1:0] mAddr = '0;
  int           mIdx = 0;
  bit           mFail = 0;
  int           mFIdx = 0;
  byte unsigned mFVal = 0;

  always #(CLK_HALF) clk = ~clk;

  cell_tester #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .targetAddr(targetAddr),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr), .memWrData(memWrData),
    .memRdData(memRdData), .memAck(memAck), .testDone(testDone), .testFail(testFail),
    .failIndex(failIndex), .failValue(failValue)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSt = 0; mIdx = 0; mFail = 0; mFIdx = 0; mFVal = 0; mAddr = '0;
    end else begin
      case (mSt)
        0: if (startPulse) begin
             mAddr = targetAddr; mIdx = 0; mFail = 0; mFIdx = 0; mFVal = 0; mSt = 1;
           end
        1: if (memAck) mSt = 2;
        2: if (memAck) begin
             if (memRdData != pats[mIdx]) begin
               mFail = 1; mFIdx = mIdx; mFVal = memRdData; mSt = 3;
             end else if (mIdx == 7) mSt = 3;
             else begin mIdx++; mSt = 1; end
           end
        default: mSt = 0;
      endcase
    end
  end

  // compare on every falling edge, then drive the sequencer model
  always @(negedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      check(1'b0, "watchdog", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
    if (rstN) begin
      check(memReq == ((mSt == 1) || (mSt == 2)), "R4 request level", memReq, (mSt == 1) || (mSt == 2));
      if (mSt == 1 || mSt == 2) begin
        check(memAddr == mAddr, "R2 request address", memAddr, mAddr);
        check(memWrite == (mSt == 1), "R4 access direction", memWrite, mSt == 1);
      end
      if (mSt == 1) check(memWrData == pats[mIdx], "R3 pattern byte", memWrData, pats[mIdx]);
      check(testDone == (mSt == 3), "R7 done pulse", testDone, mSt == 3);
      if (mSt == 3) begin
        check(testFail == mFail, mFail ? "R5 fail flag" : "R6 pass flag", testFail, mFail);
        if (mFail) begin
          check(failIndex == mFIdx, "R5 fail index", failIndex, mFIdx);
          check(failValue == mFVal, "R5 fail value", failValue, mFVal);
        end
      end
    end
    // sequencer model
    if (memAck) begin
      memAck = 1'b0;
      waitCnt = latency;
    end else if (seqEnable && memReq) begin
      if (waitCnt == 0) begin
        reqCount++;
        if (memWrite) lastWr = memWrData;
        else begin
          memRdData = lastWr | stuckHigh;
          if (readCount == corruptRead) memRdData = memRdData ^ 8'h01;
          readCount++;
        end
        memAck = 1'b1;
      end else waitCnt--;
    end
  end

  task automatic runTest(input logic [ADDR_W-1:0] addr, input int lat, input bit noisyStart,
                         output bit sawFail, output int reqs, output logic [ADDR_W-1:0] seenAddr);
    @(negedge clk);
    latency = lat; waitCnt = lat; readCount = 0; reqCount = 0; seqEnable = 1'b1;
    targetAddr = addr; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    seenAddr = memAddr;
    for (int i = 0; i < 2000; i++) begin
      if (testDone) break;
      if (noisyStart) begin
        startPulse = (i % 3 == 1);
        targetAddr = addr ^ ADDR_W'(i + 1);
      end
      @(negedge clk);
    end
    startPulse = 1'b0;
    sawFail = testFail;
    reqs = reqCount;
    @(negedge clk);
  endtask

  initial begin
    bit f;
    int n;
    logic [ADDR_W-1:0] a;
    // R1: reset behaviour
    repeat (3) @(negedge clk);
    check(!memReq && !testDone, "R1 quiet in reset", {memReq, testDone}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!memReq && !testDone, "R1 quiet after reset", {memReq, testDone}, 0);

    // R6: clean pass, no waiting
    runTest(24'h00_1234, 0, 1'b0, f, n, a);
    check(f == 1'b0, "R6 pass result", f, 0);
    check(n == 16, "R6 sixteen requests", n, 16);
    check(a == 24'h00_1234, "R2 first request address", a, 24'h00_1234);

    // R8: start noise and address changes during a slow run
    runTest(24'hAB_CDEF, 3, 1'b1, f, n, a);
    check(f == 1'b0, "R8 noisy start pass", f, 0);
    check(n == 16, "R8 request count unchanged", n, 16);

    // R5: corrupted first readback
    corruptRead = 0;
    runTest(24'h00_0001, 1, 1'b0, f, n, a);
    check(f == 1'b1 && failIndex == 0 && failValue == 8'hF1, "R5 first pattern fault",
          {f, failIndex, failValue}, {1'b1, 3'd0, 8'hF1});
    check(n == 2, "R5 stop after mismatch", n, 2);

    // R5: corrupted last readback
    corruptRead = 7;
    runTest(24'hFF_FFFF, 0, 1'b0, f, n, a);
    check(f == 1'b1 && failIndex == 7 && failValue == 8'h02, "R5 last pattern fault",
          {f, failIndex, failValue}, {1'b1, 3'd7, 8'h02});
    corruptRead = -1;

    // R5: bit 7 stuck high fails at pattern 1
    stuckHigh = 8'h80;
    runTest(24'h55_AA55, 2, 1'b0, f, n, a);
    check(f == 1'b1 && failIndex == 1 && failValue == 8'h8F, "R5 stuck bit fault",
          {f, failIndex, failValue}, {1'b1, 3'd1, 8'h8F});
    stuckHigh = 0;

    // R9: acknowledge while idle
    seqEnable = 1'b0;
    @(negedge clk);
    memAck = 1'b1; memRdData = 8'h00;
    @(negedge clk);
    @(negedge clk);
    check(!memReq && !testDone, "R9 stray ack ignored", {memReq, testDone}, 0);

    // R6: pass again after failures
    runTest(24'h10_0000, 1, 1'b0, f, n, a);
    check(f == 1'b0, "R6 pass after fail", f, 0);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule